// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block performs lane-wise addition and subtraction on two 32-bit operands that are treated either as a pair of 16-bit lanes or as four 8-bit lanes. Each lane can be read as a signed or an unsigned number. A lane result comes in one of three styles:

- **Wrapping:** the low bits of the exact result, with a greater-or-equal flag for each lane.
- **Saturating:** the exact result clamped to the lane's range.
- **Halving:** the exact result divided by two.

In 16-bit mode there is also an exchanged operation. It crosses the halves of the second operand, so that one instruction subtracts in the upper lane and adds in the lower lane.

The arithmetic is combinational. Its result sits behind one register stage with a valid/ready handshake on both sides.

- **Input side:** a request is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- **Output side:** the result is presented on the next cycle and stays stable until `out_ready` is seen high.
- **Back-pressure:** `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure therefore reaches the producer in the same cycle without a bubble, and the unit holds one request in flight at most.

A host that keeps flag state uses `out_ge_we` to decide whether to update its stored flags from `out_ge`.

Top module: `simd_addsub`

## Requirements
- R1: With `in_lane8`=0 the operands form two 16-bit lanes (lane 1 = bits 31:16, lane 0 = bits 15:0). With `in_lane8`=1 they form four 8-bit lanes, and lane i occupies bits 8i+7:8i. Each result lane is written to the same bit positions.
- R2: `in_op`=0 computes A+B in every lane and `in_op`=1 computes A-B in every lane. `in_signed`=1 treats lane values as two's complement and `in_signed`=0 treats them as unsigned.
- R3: In 16-bit mode, `in_op`=2 or 3 selects the exchanged operation: upper result = A[31:16] - B[15:0], lower result = A[15:0] + B[31:16].
- R4: In 8-bit mode, `in_op`=2 or 3 behaves exactly as add (`in_op`=0).
- R5: `in_style`=0 or 3 selects wrapping: each lane gives the low lane-width bits of the exact result, and `out_ge_we`=1.
- R6: Wrapping-style flags are set as follows: for signed lanes when the exact result is >= 0; for unsigned add on carry out; for unsigned subtract when no borrow occurs. In 8-bit mode lane i drives `out_ge[i]`. In 16-bit mode lane 1 drives bits 3:2 and lane 0 drives bits 1:0.
- R7: `in_style`=1 selects saturation: each lane result is clamped to [-2^(w-1), 2^(w-1)-1] when signed and to [0, 2^w-1] when unsigned.
- R8: `in_style`=2 selects halving: the exact result is shifted right by one bit with the sign kept, and its low lane-width bits are returned. This can never overflow.
- R9: For the saturating and halving styles `out_ge_we`=0 and `out_ge`=0.
- R10: During reset `out_valid`=0. `in_ready` = !`out_valid` || `out_ready`. A request accepted at one clock edge appears with `out_valid`=1 after that edge, and results leave in acceptance order.
- R11: While `out_valid`=1 and `out_ready`=0, the output payload and `out_valid` hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_a | input | 32 | First operand A |
| in_b | input | 32 | Second operand B |
| in_lane8 | input | 1 | 1 = four byte lanes, 0 = two halfword lanes |
| in_op | input | 2 | 0 add, 1 subtract, 2/3 exchanged subtract/add |
| in_signed | input | 1 | 1 = signed lanes |
| in_style | input | 2 | 0/3 wrap, 1 saturate, 2 halve |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_res | output | 32 | Packed lane result |
| out_ge | output | 4 | Greater-or-equal flags |
| out_ge_we | output | 1 | Flags should be written |

## Verification
The assertions check the handshake rules on every cycle:

- readiness whenever the output register is empty;
- a valid result on the cycle after acceptance;
- a held payload under stall;
- zero flags and a cleared write enable after any saturating or halving request;
- paired flag bits after any 16-bit wrapping request.

The lane arithmetic is shown only by the bench's scenarios. These cover:

- the clamping limits, exact rounding in halving and the flag conditions;
- the cross-half exchange;
- the byte-mode fallback of the exchange codes;
- random operands under random back-pressure, compared against an independent integer model.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD     = 2'd0,
    OP_SUB     = 2'd1,
    OP_XCH     = 2'd2,
    OP_XCH_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_WRAP     = 2'd0,
    ST_SAT      = 2'd1,
    ST_HALF     = 2'd2,
    ST_WRAP_ALT = 2'd3
  } style_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sgn,
  output logic [W-1:0] wrap,
  output logic [W-1:0] sat,
  output logic [W-1:0] half,
  output logic         ge
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] SMAX = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [XW-1:0] SMIN = $signed({3'b111, {(W-1){1'b0}}});
  localparam logic signed [XW-1:0] UMAX = $signed({2'b00, {W{1'b1}}});

  logic signed [XW-1:0] ea, eb, full;

  always_comb begin
    ea   = sgn ? $signed({{2{a[W-1]}}, a}) : $signed({2'b00, a});
    eb   = sgn ? $signed({{2{b[W-1]}}, b}) : $signed({2'b00, b});
    full = sub ? (ea - eb) : (ea + eb);
  end

  assign wrap = full[W-1:0];
  assign half = full[W:1];

  always_comb begin
    sat = full[W-1:0];
    if (sgn) begin
      if (full > SMAX)      sat = {1'b0, {(W-1){1'b1}}};
      else if (full < SMIN) sat = {1'b1, {(W-1){1'b0}}};
    end else begin
      if (full[XW-1])       sat = '0;
      else if (full > UMAX) sat = '1;
    end
  end

  assign ge = (sgn || sub) ? ~full[XW-1] : full[W];
endmodule

// File: rtl/simd_core.sv
module simd_core
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              lane8,
  input  op_e               op,
  input  logic              sgn,
  input  style_e            style,
  output logic [DATA_W-1:0] res,
  output logic [3:0]        ge,
  output logic              ge_we
);
  localparam int HW = DATA_W / 2;
  localparam int BW = DATA_W / 4;

  logic xch;
  assign xch = (op == OP_XCH) || (op == OP_XCH_ALT);

  logic [DATA_W-1:0] h_wrap, h_sat, h_half;
  logic [DATA_W-1:0] q_wrap, q_sat, q_half;
  logic [1:0]        h_ge;
  logic [3:0]        q_ge;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int  OTHER = 1 - h;
    localparam bit  UPPER = (h == 1);
    logic [HW-1:0] rhs;
    logic          sub;
    assign rhs = xch ? b[OTHER*HW +: HW] : b[h*HW +: HW];
    assign sub = (op == OP_SUB) || (xch && UPPER);
    simd_lane #(.W(HW)) u_lane (
      .a    (a[h*HW +: HW]),
      .b    (rhs),
      .sub  (sub),
      .sgn  (sgn),
      .wrap (h_wrap[h*HW +: HW]),
      .sat  (h_sat[h*HW +: HW]),
      .half (h_half[h*HW +: HW]),
      .ge   (h_ge[h])
    );
  end

  for (genvar q = 0; q < 4; q++) begin : g_byte
    simd_lane #(.W(BW)) u_lane (
      .a    (a[q*BW +: BW]),
      .b    (b[q*BW +: BW]),
      .sub  (op == OP_SUB),
      .sgn  (sgn),
      .wrap (q_wrap[q*BW +: BW]),
      .sat  (q_sat[q*BW +: BW]),
      .half (q_half[q*BW +: BW]),
      .ge   (q_ge[q])
    );
  end

  logic [DATA_W-1:0] h_pick, q_pick;
  logic [3:0]        flags;

  always_comb begin
    case (style)
      ST_SAT:  begin h_pick = h_sat;  q_pick = q_sat;  end
      ST_HALF: begin h_pick = h_half; q_pick = q_half; end
      default: begin h_pick = h_wrap; q_pick = q_wrap; end
    endcase
    res   = lane8 ? q_pick : h_pick;
    flags = lane8 ? q_ge : {h_ge[1], h_ge[1], h_ge[0], h_ge[0]};
    ge_we = (style == ST_WRAP) || (style == ST_WRAP_ALT);
    ge    = ge_we ? flags : 4'b0000;
  end
endmodule

// File: rtl/simd_stage.sv
module simd_stage #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_lane8,
  input  logic [1:0]        in_op,
  input  logic              in_signed,
  input  logic [1:0]        in_style,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic [3:0]        out_ge,
  output logic              out_ge_we
);
  localparam int PW = DATA_W + 5;

  logic [DATA_W-1:0] c_res;
  logic [3:0]        c_ge;
  logic              c_we;
  logic [PW-1:0]     q_data;

  simd_core #(.DATA_W(DATA_W)) u_core (
    .a     (in_a),
    .b     (in_b),
    .lane8 (in_lane8),
    .op    (op_e'(in_op)),
    .sgn   (in_signed),
    .style (style_e'(in_style)),
    .res   (c_res),
    .ge    (c_ge),
    .ge_we (c_we)
  );

  simd_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({c_we, c_ge, c_res}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (q_data)
  );

  assign out_res   = q_data[DATA_W-1:0];
  assign out_ge    = q_data[DATA_W+3:DATA_W];
  assign out_ge_we = q_data[DATA_W+4];

  // R9
  no_flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_style == 2'd1 || in_style == 2'd2))
      |=> (!out_ge_we && out_ge == 4'b0000));

  // R6
  half_flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_lane8 && (in_style == 2'd0 || in_style == 2'd3))
      |=> (out_ge_we && out_ge[3] == out_ge[2] && out_ge[1] == out_ge[0]));
endmodule

// File: tb/sim_simd_addsub.sv
`timescale 1ns/1ps
module sim_simd_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_lane8 = 1'b0;
  logic [1:0]  in_op = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_style = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_res;
  logic [3:0]  out_ge;
  logic        out_ge_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit sending = 1;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  ge;
    logic        we;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  simd_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_lane8(in_lane8), .in_op(in_op),
    .in_signed(in_signed), .in_style(in_style), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_ge(out_ge), .out_ge_we(out_ge_we)
  );

  function automatic item_t model(logic [31:0] a, logic [31:0] b, logic l8,
                                  logic [1:0] op, logic sg, logic [1:0] st);
    item_t it;
    int w = l8 ? 8 : 16;
    int n = l8 ? 4 : 2;
    longint mask = (longint'(1) <<< w) - 1;
    logic [3:0] flags = '0;
    it.res = '0;
    for (int i = 0; i < n; i++) begin
      bit x = !l8 && op[1];
      int bi = x ? (1 - i) : i;
      bit sub = x ? (i == 1) : (op == 2'd1);
      longint av = (longint'(a) >>> (i * w)) & mask;
      longint bv = (longint'(b) >>> (bi * w)) & mask;
      longint full, r;
      bit g;
      if (sg && av[w-1]) av = av - (mask + 1);
      if (sg && bv[w-1]) bv = bv - (mask + 1);
      full = sub ? av - bv : av + bv;
      if (st == 2'd1) begin
        longint lo = sg ? -((mask + 1) / 2) : 0;
        longint hi = sg ? (mask + 1) / 2 - 1 : mask;
        r = full > hi ? hi : (full < lo ? lo : full);
      end else if (st == 2'd2) r = full >>> 1;
      else r = full;
      r = r & mask;
      it.res = it.res | (32'(r) << (i * w));
      g = (sg || sub) ? (full >= 0) : (full > mask);
      if (l8) flags[i] = g;
      else begin flags[2*i] = g; flags[2*i+1] = g; end
    end
    it.we = (st == 2'd0) || (st == 2'd3);
    it.ge = it.we ? flags : 4'b0;
    return it;
  endfunction

  task automatic send(logic [31:0] a, logic [31:0] b, logic l8, logic [1:0] op,
                      logic sg, logic [1:0] st, string tag);
    item_t it = model(a, b, l8, op, sg, st);
    it.tag = tag;
    @(negedge clk);
    in_a = a; in_b = b; in_lane8 = l8; in_op = op; in_signed = sg; in_style = st;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_val(item_t e, item_t got);
    checks++;
    if (got.res !== e.res || got.ge !== e.ge || got.we !== e.we) begin
      errors++;
      $display("FAIL %s res=%h ge=%b we=%b expected res=%h ge=%b we=%b",
               e.tag, got.res, got.ge, got.we, e.res, e.ge, e.we);
    end
  endtask

  // monitor: random back-pressure, pop and compare in order (R10, R11)
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #2;
      if (out_valid && out_ready) begin
        item_t got;
        got.res = out_res; got.ge = out_ge; got.we = out_ge_we; got.tag = "";
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected result %h expected none", out_res);
        end else expect_val(sb.pop_front(), got);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog pending=%0d expected 0", sb.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 halfword wrap add/sub
    send(32'h1234_8000, 32'h0001_8000, 0, 2'd0, 0, 2'd0, "R1 R2 R6 u16 add carry");
    send(32'h0005_0003, 32'h0007_0003, 0, 2'd1, 0, 2'd0, "R2 R6 u16 sub borrow");
    send(32'hFFFF_0001, 32'h0001_0002, 0, 2'd1, 1, 2'd0, "R2 R6 s16 sub sign");
    send(32'h01FF_7F80, 32'h0101_0180, 1, 2'd0, 0, 2'd0, "R1 R6 u8 add carry");
    send(32'h80_7F_00_05, 32'h01_FF_00_06, 1, 2'd1, 1, 2'd0, "R1 R6 s8 sub");
    // R3 exchange
    send(32'h0010_0003, 32'h0002_0005, 0, 2'd2, 0, 2'd0, "R3 u16 exchange");
    send(32'h8000_7FFF, 32'h0001_0001, 0, 2'd3, 1, 2'd1, "R3 R7 s16 exchange sat");
    // R4 byte exchange codes fall back to add
    send(32'h10_20_30_40, 32'h01_02_03_04, 1, 2'd2, 0, 2'd0, "R4 u8 op2 as add");
    send(32'hFF_80_7F_01, 32'h01_80_01_FF, 1, 2'd3, 1, 2'd0, "R4 s8 op3 as add");
    // R5 style code 3 behaves as wrap
    send(32'hFFFF_FFFF, 32'h0001_0002, 0, 2'd0, 0, 2'd3, "R5 style3 wrap");
    // R7 saturation limits
    send(32'h7FFF_8000, 32'h0001_0001, 0, 2'd0, 1, 2'd1, "R7 R9 s16 add clamp");
    send(32'h8000_7FFF, 32'h0001_FFFF, 0, 2'd1, 1, 2'd1, "R7 s16 sub clamp");
    send(32'h0001_FFF0, 32'h0002_0020, 0, 2'd1, 0, 2'd1, "R7 u16 sub floor");
    send(32'hF0_10_80_7F, 32'h20_01_80_01, 1, 2'd0, 0, 2'd1, "R7 u8 add ceiling");
    send(32'h7F_80_40_C0, 32'h01_01_40_C0, 1, 2'd0, 1, 2'd1, "R7 s8 add clamp");
    // R8 halving
    send(32'h7FFF_8000, 32'h7FFF_8000, 0, 2'd0, 1, 2'd2, "R8 R9 s16 half add");
    send(32'hFFFF_0000, 32'hFFFF_FFFF, 0, 2'd0, 0, 2'd2, "R8 u16 half add");
    send(32'h00_01_80_7F, 32'hFF_02_7F_80, 1, 2'd1, 0, 2'd2, "R8 u8 half sub");
    send(32'h80_01_7F_FF, 32'h7F_02_80_01, 1, 2'd1, 1, 2'd2, "R8 s8 half sub");
    send(32'h0003_0005, 32'h0008_0002, 0, 2'd2, 1, 2'd2, "R3 R8 exchange half");

    for (int k = 0; k < 400; k++) begin
      logic [1:0] st = 2'($urandom);
      string tg = (st == 2'd1) ? "R7 random" : ((st == 2'd2) ? "R8 random" : "R5 R6 random");
      send($urandom, $urandom, 1'($urandom), 2'($urandom), 1'($urandom), st, tg);
    end

    sending = 0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule